// File: doc/BRIEF.md
# Bitstream Sample Timing Controller

This block produces the sampling strobe for a one-bit, density-modulated data stream. It runs from a master clock and takes one data bit in every sixteen clock cycles. It reports the bit it captured, a one-cycle sample strobe, and an update strobe that follows each sample after a fixed delay. At the edge of the update strobe it also drives a two-bit steering code to the downstream current-steering filter. It keeps a clear line to that filter asserted while the block is reset or powered down.

Two level inputs control the sampling phase. Both pass through a two-flop synchroniser first. A low on the synchronisation input stops the phase counter and freezes the steering code. When the input returns high, the counter restarts at a fixed offset, so several units fed the same stream sample it on the same clock. The active-low power-down input also stops sampling, and in addition it sets the steering code to neutral and raises the clear line. When neither input is used, both are tied high and sampling runs freely from the release of reset.

Top module: `density_sample_timer`

## Requirements
- R1: While rst_n is low: dac_drv_o is 2'b00, tap_clr_o is 1, and both strobes are 0. With pdn_n_i high, tap_clr_o drops at the first rising edge after reset release.
- R2: With sync_i and pdn_n_i held high through reset, the first sample is taken on the sixth rising edge after reset release. After that edge, samp_stb_o is high for one cycle and samp_bit_o holds the value bit_i had at that edge.
- R3: Each later sample comes exactly 16 rising edges after the one before it. samp_stb_o is never high at any other time.
- R4: upd_stb_o is high for one cycle, 4 rising edges after each sample edge. At that same edge dac_drv_o takes the code of the sampled bit: 2'b10 for a 1, 2'b01 for a 0. The code 2'b00 is neutral, and no other value ever appears.
- R5: While the synchronised sync level is low, no strobe is produced, bit_i has no effect, and dac_drv_o keeps its last value.
- R6: Count as edge 1 the rising edge at which sync_i is first sampled high. The first sample then falls on edge 8, which is two synchroniser stages plus six edges. Samples follow every 16 edges after that.
- R7: A sync_i low that is seen at two consecutive rising edges is enough to realign the phase as R6 describes.
- R8: After pdn_n_i is first sampled low, by the third rising edge dac_drv_o is 2'b00, tap_clr_o is 1, and no strobe follows.
- R9: Count as edge 1 the rising edge at which pdn_n_i is first sampled high again. tap_clr_o falls at edge 3, dac_drv_o stays 2'b00 until the first update, and the first sample falls on edge 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bit_i | input | 1 | Density-modulated data bit |
| sync_i | input | 1 | Phase synchronisation level; low stops sampling |
| pdn_n_i | input | 1 | Active-low power-down level |
| samp_bit_o | output | 1 | Most recently captured data bit |
| samp_stb_o | output | 1 | One-cycle pulse after each sample edge |
| upd_stb_o | output | 1 | One-cycle pulse, a fixed latency after each sample |
| dac_drv_o | output | 2 | Steering code: 10 positive, 01 negative, 00 neutral |
| tap_clr_o | output | 1 | Clear request to the downstream filter |

## Verification
The properties assume that sync_i and pdn_n_i are slow levels. Each low is held for at least two clock periods, and none of them changes inside the four-cycle window between a sample and its update. Under those assumptions, consecutive samples are at least six edges apart, and each update strobe lines up with exactly one earlier sample. The bench keeps to these assumptions. It changes bit_i and both control levels only on falling clock edges, and it only drops sync or power-down after the pending update has appeared. This leaves a full stretch of quiet cycles for every disturbance and for the strobes that must stay absent.

// File: rtl/dst_pkg.sv
package dst_pkg;

  // Steering code toward the current-steering filter.
  typedef enum logic [1:0] {
    DRV_MID = 2'b00,
    DRV_NEG = 2'b01,
    DRV_POS = 2'b10
  } drv_e;

  // Code for one captured bit.
  function automatic drv_e drv_of(input logic b);
    return b ? DRV_POS : DRV_NEG;
  endfunction

  // The phase counter reads ph just before the edge that takes a sample.
  // Edge n of a run (n = 1 at the first enabled edge) sees ph = n-1 mod period.
  function automatic logic hits_sample(input int unsigned ph,
                                       input int unsigned first_edge,
                                       input int unsigned period);
    return ph == ((first_edge - 1) % period);
  endfunction

  // Next phase count, wrapping at the period.
  function automatic int unsigned phase_next(input int unsigned ph,
                                             input int unsigned period);
    return (ph == period - 1) ? 0 : ph + 1;
  endfunction

endpackage

// File: rtl/dst_lvl_sync.sv
module dst_lvl_sync #(
  parameter int unsigned     N       = 2,
  parameter logic [N-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        stab_q <= meta_q;
      end
    end
    assign q_o[g] = stab_q;
  end

endmodule

// File: rtl/dst_phase_gen.sv
module dst_phase_gen
  import dst_pkg::*;
#(
  parameter int unsigned PERIOD     = 16,
  parameter int unsigned FIRST_EDGE = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic bit_i,
  output logic stb_o,
  output logic bit_o
);

  localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_d;
  logic          hit;
  logic          stb_q;
  logic          bit_q;

  always_comb begin
    hit  = run_i && hits_sample(int'(ph_q), FIRST_EDGE, PERIOD);
    ph_d = run_i ? PW'(phase_next(int'(ph_q), PERIOD)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      stb_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      stb_q <= hit;
      if (hit) bit_q <= bit_i;
    end
  end

  assign stb_o = stb_q;
  assign bit_o = bit_q;

endmodule

// File: rtl/dst_upd_pipe.sv
module dst_upd_pipe #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic stb_i,
  output logic fire_nxt_o,
  output logic fire_o
);

  logic [DEPTH-1:0] st_q;
  logic [DEPTH-1:0] st_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_st
    if (g == 0) begin : g_head
      assign st_d[g] = run_i & stb_i;
    end else begin : g_body
      assign st_d[g] = run_i & st_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign fire_nxt_o = st_d[DEPTH-1];
  assign fire_o     = st_q[DEPTH-1];

endmodule

// File: rtl/dst_out_stage.sv
module dst_out_stage
  import dst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_i,
  input  logic       load_i,
  input  logic       bit_i,
  output logic [1:0] drv_o,
  output logic       clr_o
);

  drv_e drv_q;
  logic clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= DRV_MID;
      clr_q <= 1'b1;
    end else if (!pwr_i) begin
      drv_q <= DRV_MID;
      clr_q <= 1'b1;
    end else begin
      clr_q <= 1'b0;
      if (load_i) drv_q <= drv_of(bit_i);
    end
  end

  assign drv_o = drv_q;
  assign clr_o = clr_q;

endmodule

// File: rtl/density_sample_timer.sv
module density_sample_timer #(
  parameter int unsigned PERIOD     = 16,
  parameter int unsigned FIRST_EDGE = 6,
  parameter int unsigned UPD_LAT    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_i,
  input  logic       sync_i,
  input  logic       pdn_n_i,
  output logic       samp_bit_o,
  output logic       samp_stb_o,
  output logic       upd_stb_o,
  output logic [1:0] dac_drv_o,
  output logic       tap_clr_o
);

  localparam int unsigned NLVL = 2;
  localparam int unsigned ISYN = 0;
  localparam int unsigned IPWR = 1;

  // Named internal events
  logic [NLVL-1:0] lvl_raw;
  logic [NLVL-1:0] lvl_q;
  logic            sync_lvl;
  logic            pwr_lvl;
  logic            run_en;
  logic            samp_stb;
  logic            samp_bit;
  logic            upd_load;
  logic            upd_fire;

  assign lvl_raw[ISYN] = sync_i;
  assign lvl_raw[IPWR] = pdn_n_i;

  // Both levels come out of reset "high" so a tied-high setup starts at once.
  dst_lvl_sync #(.N(NLVL), .RST_VAL({NLVL{1'b1}})) u_lvl (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (lvl_raw),
    .q_o   (lvl_q)
  );

  assign sync_lvl = lvl_q[ISYN];
  assign pwr_lvl  = lvl_q[IPWR];
  assign run_en   = sync_lvl & pwr_lvl;

  dst_phase_gen #(.PERIOD(PERIOD), .FIRST_EDGE(FIRST_EDGE)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (run_en),
    .bit_i (bit_i),
    .stb_o (samp_stb),
    .bit_o (samp_bit)
  );

  dst_upd_pipe #(.DEPTH(UPD_LAT)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_en),
    .stb_i      (samp_stb),
    .fire_nxt_o (upd_load),
    .fire_o     (upd_fire)
  );

  dst_out_stage u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_i  (pwr_lvl),
    .load_i (upd_load),
    .bit_i  (samp_bit),
    .drv_o  (dac_drv_o),
    .clr_o  (tap_clr_o)
  );

  assign samp_bit_o = samp_bit;
  assign samp_stb_o = samp_stb;
  assign upd_stb_o  = upd_fire;

endmodule

// File: rtl/dst_chk.sv
module dst_chk #(
  parameter int unsigned PERIOD     = 16,
  parameter int unsigned FIRST_EDGE = 6,
  parameter int unsigned UPD_LAT    = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       samp_bit_o,
  input logic       samp_stb_o,
  input logic       upd_stb_o,
  input logic [1:0] dac_drv_o,
  input logic       tap_clr_o
);

  localparam int unsigned SW = $clog2(PERIOD) + 3;

  // Cycles since the last sample strobe, saturating.
  logic [SW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             since_q <= '1;
    else if (samp_stb_o)    since_q <= SW'(1);
    else if (since_q != '1) since_q <= since_q + 1'b1;
  end

  // R3
  samp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb_o |=> !samp_stb_o);

  // R3
  samp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb_o |-> since_q >= SW'(FIRST_EDGE));

  // R4
  upd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb_o |-> since_q == SW'(UPD_LAT));

  // R4
  upd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb_o |-> dac_drv_o == {samp_bit_o, ~samp_bit_o});

  // R4
  drv_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dac_drv_o));

  // R5
  drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_drv_o != $past(dac_drv_o)) |-> (upd_stb_o || dac_drv_o == 2'b00));

  // R8
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_clr_o |-> (dac_drv_o == 2'b00 && !samp_stb_o && !upd_stb_o));

endmodule

bind density_sample_timer dst_chk #(
  .PERIOD     (PERIOD),
  .FIRST_EDGE (FIRST_EDGE),
  .UPD_LAT    (UPD_LAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .samp_bit_o (samp_bit_o),
  .samp_stb_o (samp_stb_o),
  .upd_stb_o  (upd_stb_o),
  .dac_drv_o  (dac_drv_o),
  .tap_clr_o  (tap_clr_o)
);

// File: tb/sim_density_sample_timer.sv
module sim_density_sample_timer;

  localparam int PER = 16;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_i = 1'b0;
  logic       sync_i = 1'b1;
  logic       pdn_n_i = 1'b1;
  logic       samp_bit_o;
  logic       samp_stb_o;
  logic       upd_stb_o;
  logic [1:0] dac_drv_o;
  logic       tap_clr_o;

  density_sample_timer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_i      (bit_i),
    .sync_i     (sync_i),
    .pdn_n_i    (pdn_n_i),
    .samp_bit_o (samp_bit_o),
    .samp_stb_o (samp_stb_o),
    .upd_stb_o  (upd_stb_o),
    .dac_drv_o  (dac_drv_o),
    .tap_clr_o  (tap_clr_o)
  );

  always #10 clk = ~clk;   // 50 MHz

  int cyc = 0;             // number of rising edges so far
  always @(posedge clk) cyc <= cyc + 1;

  int errs = 0;
  int chks = 0;
  int mode = 3;
  int quiet_req = 3;
  bit fin = 1'b0;

  typedef struct {
    int   edge_n;
    logic b;
    int   req;
  } exp_t;

  exp_t sq[$];
  exp_t uq[$];

  function automatic logic pat(input int m, input int k);
    logic [31:0] h;
    h = 32'(k) * 32'd2654435761;
    case (m)
      0:       return 1'b1;
      1:       return 1'b0;
      2:       return k[0];
      default: return h[19] ^ h[6];
    endcase
  endfunction

  function automatic logic [1:0] code_of(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d (edge %0d)",
               req, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, chks);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Driver: expected sample and update items for a run of n samples.
  task automatic push_run(input int first, input int n, input int req_first);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.edge_n = first + PER * i;
      e.b      = pat(mode, e.edge_n);
      e.req    = (i == 0) ? req_first : 3;   // later ones are R3 spacing
      sq.push_back(e);
      e.edge_n = e.edge_n + LAT;
      e.req    = 4;                          // R4 latency and code
      uq.push_back(e);
    end
  endtask

  // Data source: value seen at edge k is pat(mode, k).
  initial forever begin
    @(negedge clk);
    bit_i = pat(mode, cyc + 1);
  end

  // Monitor / scoreboard
  initial forever begin
    exp_t e;
    @(negedge clk);
    if (rst_n) begin
      if (sq.size() > 0 && sq[0].edge_n == cyc) begin
        e = sq.pop_front();
        check(samp_stb_o == 1'b1, e.req, "sample strobe", int'(samp_stb_o), 1);
        check(samp_bit_o == e.b, e.req, "sample bit", int'(samp_bit_o), int'(e.b));
      end else if (samp_stb_o) begin
        check(1'b0, quiet_req, "unexpected sample strobe", 1, 0);
      end
      if (uq.size() > 0 && uq[0].edge_n == cyc) begin
        e = uq.pop_front();
        check(upd_stb_o == 1'b1, e.req, "update strobe", int'(upd_stb_o), 1);
        check(dac_drv_o == code_of(e.b), e.req, "drive code",
              int'(dac_drv_o), int'(code_of(e.b)));
      end else if (upd_stb_o) begin
        check(1'b0, quiet_req, "unexpected update strobe", 1, 0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      errs++;
      chks++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [1:0] held;

    // R1: state during reset
    wait_cyc(1);
    check(dac_drv_o == 2'b00, 1, "drive in reset", int'(dac_drv_o), 0);
    check(tap_clr_o == 1'b1, 1, "clear in reset", int'(tap_clr_o), 1);
    check(!samp_stb_o && !upd_stb_o, 1, "strobes in reset",
          int'({samp_stb_o, upd_stb_o}), 0);

    // R2: release after edge 3, first sample on edge 9 (sixth after release)
    wait_cyc(3);
    mode = 3;
    push_run(9, 5, 2);
    rst_n = 1'b1;
    wait_cyc(4);
    check(tap_clr_o == 1'b0, 1, "clear after release", int'(tap_clr_o), 0);
    wait_cyc(12);
    check(dac_drv_o == 2'b00, 4, "neutral before first update", int'(dac_drv_o), 0);

    // R5: sync low after the last update (edge 77)
    wait_cyc(78);
    held = dac_drv_o;
    quiet_req = 5;
    mode = 2;
    sync_i = 1'b0;
    wait_cyc(90);
    check(dac_drv_o == held, 5, "drive held while sync low", int'(dac_drv_o), int'(held));
    mode = 0;
    wait_cyc(100);
    check(dac_drv_o == held, 5, "drive held, data ignored", int'(dac_drv_o), int'(held));

    // R6: sync seen high at edge 101, first sample at edge 108
    mode = 3;
    push_run(108, 3, 6);
    sync_i = 1'b1;
    quiet_req = 3;

    // R7: two-cycle sync low seen at edges 146,147; high seen at 148 -> 155
    wait_cyc(145);
    quiet_req = 7;
    sync_i = 1'b0;
    wait_cyc(147);
    push_run(155, 2, 7);
    sync_i = 1'b1;

    // R8: power-down seen at edge 177, cleared after edge 179
    wait_cyc(176);
    quiet_req = 8;
    mode = 1;
    pdn_n_i = 1'b0;
    wait_cyc(179);
    check(dac_drv_o == 2'b00, 8, "drive cleared in power-down", int'(dac_drv_o), 0);
    check(tap_clr_o == 1'b1, 8, "clear in power-down", int'(tap_clr_o), 1);
    wait_cyc(195);
    check(dac_drv_o == 2'b00 && tap_clr_o, 8, "still powered down",
          int'({tap_clr_o, dac_drv_o}), 4);

    // R9: release seen at edge 196, clear drops at 198, sample at 203
    push_run(203, 2, 9);
    pdn_n_i = 1'b1;
    quiet_req = 9;
    wait_cyc(198);
    check(tap_clr_o == 1'b0, 9, "clear released", int'(tap_clr_o), 0);
    wait_cyc(206);
    check(dac_drv_o == 2'b00, 9, "neutral until first update", int'(dac_drv_o), 0);

    wait_cyc(230);
    check(sq.size() == 0 && uq.size() == 0, 3, "all expected events seen",
          sq.size() + uq.size(), 0);

    fin = 1'b1;
    summary();
    $finish;
  end

endmodule